// File: doc/BRIEF.md
# Synchronous PSRAM-Style Slave Bridge

This block sits in an FPGA and answers a microcontroller's external memory controller, which addresses it as if it were synchronous pseudo-static RAM with a free-running bus clock. Every bus access is a single beat on one chip select. Address and data use separate pins. Data moves a fixed number of clocks after the address-valid edge, so the master never stretches a transfer. The bridge turns each accepted access into one request on a simple valid/ready internal port. Only one request may be outstanding at a time. While that request is unfinished, the active-low wait output is held low.

Because the internal side may be slow, reads take two bus accesses. The first read of an address only starts an internal fetch. The master discards whatever that first read returns, then polls the wait line until it goes high. A second read of the same address then delivers the fetched word from a one-entry buffer. Writes take one access: the data beat is passed inward, and the wait line stays low until the internal side acknowledges it.

Top module: `psram_sync_slave`

## Requirements
- R1: While reset is asserted and right after it, `bus_nwait` is 1, `usr_valid` is 0 and `bus_doe` is 0.
- R2: The internal word address equals `bus_addr[25:2]` as sampled at the address edge. Byte-offset bits 1:0 have no effect on it.
- R3: The address edge is a rising clock edge with `bus_ne`=0 and `bus_nadv`=0. On a read with `bus_noe`=0, `bus_doe` is 1 and `bus_dout` is valid during exactly one cycle, the one that ends at the third rising edge after the address edge. On a write, `bus_din` is sampled at that third edge.
- R4: A read while idle whose address is not in the buffer returns 0 and issues one read request for that word. `bus_nwait` goes low after the address edge and returns high after the edge at which `usr_ack` is sampled.
- R5: A read while idle that hits the buffered address returns the fetched word, issues no request and leaves `bus_nwait` high. The hit consumes the buffer, so a further read of that address starts a new fetch.
- R6: A read of an address other than the buffered one returns 0 rather than the buffered word, and fetches the new address.
- R7: A write issues one request with `usr_write`=1 and the sampled address and data. `bus_nwait` is low from the address edge until the acknowledge. Any buffered read word is discarded.
- R8: `usr_valid` and the request fields hold until `usr_ready` is sampled high. An address phase that arrives while a request is unfinished is ignored: it returns 0 and creates no request. `usr_ack` has no effect unless a handed-over request is waiting for it.
- R9: When `usr_ack` and a new address edge fall on the same clock edge, the acknowledge completes the pending request and the new access is ignored, as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_ne | input | 1 | Chip select, active low |
| bus_nwe | input | 1 | Write enable, active low |
| bus_noe | input | 1 | Output enable, active low |
| bus_nadv | input | 1 | Address valid, active low |
| bus_addr | input | 26 | Byte address from the master |
| bus_din | input | 32 | Write data from the master |
| bus_dout | output | 32 | Read data toward the master |
| bus_doe | output | 1 | High when the bridge drives the data pins |
| bus_nwait | output | 1 | Low while an internal access is unfinished |
| usr_valid | output | 1 | Internal request valid |
| usr_ready | input | 1 | Internal request accepted |
| usr_addr | output | 24 | Internal word address |
| usr_write | output | 1 | Request is a write |
| usr_wdata | output | 32 | Internal write data |
| usr_ack | input | 1 | Internal access finished |
| usr_rdata | input | 32 | Read data, valid with usr_ack |

## Verification
The collision that matters is an internal acknowledge landing on the same edge as a new address phase. If the bridge decided using the post-acknowledge state, it would start a second access before the master has polled.

The bench provokes this by handing a fetch over by hand, then raising `usr_ack` and the address-valid strobe in the same cycle. It judges the outcome by four observations: the wait line is high at the next sample, no new request appears, the data beat is zero, and a later read of the first address returns the acknowledged word.

// File: rtl/psb_pkg.sv
// Shared types for the synchronous PSRAM-style slave bridge.
package psb_pkg;

    // Request sequencer states; IDLE is the only state with wait released.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDATA = 2'd1,
        ST_REQ   = 2'd2,
        ST_RESP  = 2'd3
    } psb_state_e;

endpackage

// File: rtl/psb_bus_phase.sv
// Bus-side timing of the bridge.
// Does: detects the address edge, counts the fixed latency, drives one
// read data beat and presents the write beat to the sequencer.
// Assumes: single-beat accesses, LAT >= 2, and no new address phase
// until the data edge of the previous access has passed.
module psb_bus_phase #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int LAT    = 3,
    localparam int WORD_W = ADDR_W - 2,
    localparam int CNT_W  = $clog2(LAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ne,
    input  logic              bus_nwe,
    input  logic              bus_noe,
    input  logic              bus_nadv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    input  logic [DATA_W-1:0] rd_word,
    output logic              addr_strobe,
    output logic              strobe_write,
    output logic [WORD_W-1:0] strobe_word,
    output logic              data_fire,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe
);

    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(LAT);
    localparam logic [CNT_W-1:0] CNT_DRIVE = CNT_W'(LAT - 1);

    logic             active_q;
    logic             acc_wr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             drive_fire;

    // Address edge decode and the beat strobes seen by the sequencer.
    always_comb begin
        addr_strobe  = !active_q && !bus_ne && !bus_nadv;
        strobe_write = !bus_nwe;
        strobe_word  = bus_addr[ADDR_W-1:2];
        drive_fire   = active_q && (cnt_q == CNT_DRIVE);
        data_fire    = active_q && (cnt_q == CNT_LAST);
        wr_data      = bus_din;
    end

    // Latency counter: runs from the address edge to the data edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            acc_wr_q <= 1'b0;
            cnt_q    <= '0;
        end else if (addr_strobe) begin
            active_q <= 1'b1;
            acc_wr_q <= strobe_write;
            cnt_q    <= CNT_W'(1);
        end else if (data_fire) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (active_q) begin
            cnt_q    <= cnt_q + CNT_W'(1);
        end
    end

    // Read beat register: valid for the single cycle before the data edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_dout <= '0;
            bus_doe  <= 1'b0;
        end else if (drive_fire && !acc_wr_q && !bus_noe) begin
            bus_dout <= rd_word;
            bus_doe  <= 1'b1;
        end else begin
            bus_dout <= '0;
            bus_doe  <= 1'b0;
        end
    end

    // R3
    doe_one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_doe |=> !bus_doe);

    // R3
    doe_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && strobe_write) |=> ##1 !bus_doe ##1 !bus_doe);

endmodule

// File: rtl/psb_fetch_ctrl.sv
// Request sequencer and one-entry read buffer of the bridge.
// Does: decides hit, miss, write or ignore at each address edge, holds the
// single internal request, releases wait on acknowledge and keeps the
// fetched word for the second read.
// Assumes: the internal side acknowledges only after accepting a request.
module psb_fetch_ctrl
    import psb_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic              strobe_write,
    input  logic [WORD_W-1:0] strobe_word,
    input  logic              data_fire,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic              bus_nwait,
    output logic              usr_valid,
    input  logic              usr_ready,
    output logic [WORD_W-1:0] usr_addr,
    output logic              usr_write,
    output logic [DATA_W-1:0] usr_wdata,
    input  logic              usr_ack,
    input  logic [DATA_W-1:0] usr_rdata
);

    psb_state_e        state_q;
    logic [WORD_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic              req_write_q;
    logic              buf_valid_q;
    logic [WORD_W-1:0] buf_addr_q;
    logic [DATA_W-1:0] buf_data_q;
    logic              hit;

    // Buffer match for an incoming read.
    always_comb hit = buf_valid_q && (buf_addr_q == strobe_word);

    // Port view of the held request and the wait line.
    always_comb begin
        usr_valid = (state_q == ST_REQ);
        usr_addr  = req_addr_q;
        usr_write = req_write_q;
        usr_wdata = req_wdata_q;
        bus_nwait = (state_q == ST_IDLE);
    end

    // Sequencer: one outstanding request, buffer fill on read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            req_addr_q  <= '0;
            req_wdata_q <= '0;
            req_write_q <= 1'b0;
            buf_valid_q <= 1'b0;
            buf_addr_q  <= '0;
            buf_data_q  <= '0;
            rd_word     <= '0;
        end else begin
            if (addr_strobe && state_q != ST_IDLE) begin
                rd_word <= '0;
            end
            case (state_q)
                ST_IDLE: begin
                    if (addr_strobe) begin
                        buf_valid_q <= 1'b0;
                        if (strobe_write) begin
                            req_addr_q  <= strobe_word;
                            req_write_q <= 1'b1;
                            rd_word     <= '0;
                            state_q     <= ST_WDATA;
                        end else if (hit) begin
                            rd_word     <= buf_data_q;
                        end else begin
                            req_addr_q  <= strobe_word;
                            req_write_q <= 1'b0;
                            rd_word     <= '0;
                            state_q     <= ST_REQ;
                        end
                    end
                end
                ST_WDATA: begin
                    if (data_fire) begin
                        req_wdata_q <= wr_data;
                        state_q     <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (usr_ready) begin
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (usr_ack) begin
                        state_q <= ST_IDLE;
                        if (!req_write_q) begin
                            buf_valid_q <= 1'b1;
                            buf_addr_q  <= req_addr_q;
                            buf_data_q  <= usr_rdata;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (usr_valid && !usr_ready) |=> (usr_valid && $stable(usr_addr) && $stable(usr_write)));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && !bus_nwait && !usr_valid) |=> !usr_valid);

    // R7
    write_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_fire && state_q == ST_WDATA) |=> (usr_valid && usr_write && !bus_nwait));

    // R5
    hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && bus_nwait && !strobe_write && hit) |=> (bus_nwait && !usr_valid));

    // R9
    ack_collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_strobe && usr_ack && state_q == ST_RESP) |=> (bus_nwait && !usr_valid));

endmodule

// File: rtl/psram_sync_slave.sv
// Top of the synchronous PSRAM-style slave bridge.
// Does: joins the bus timing unit and the request sequencer.
// Assumes: all bus inputs are synchronous to clk; pin tristating and any
// clock-domain crossing are handled outside.
module psram_sync_slave #(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int LAT    = 3,
    localparam int WORD_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ne,
    input  logic              bus_nwe,
    input  logic              bus_noe,
    input  logic              bus_nadv,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_nwait,
    output logic              usr_valid,
    input  logic              usr_ready,
    output logic [WORD_W-1:0] usr_addr,
    output logic              usr_write,
    output logic [DATA_W-1:0] usr_wdata,
    input  logic              usr_ack,
    input  logic [DATA_W-1:0] usr_rdata
);

    logic              addr_strobe;
    logic              strobe_write;
    logic [WORD_W-1:0] strobe_word;
    logic              data_fire;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_word;

    psb_bus_phase #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LAT   (LAT)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_ne      (bus_ne),
        .bus_nwe     (bus_nwe),
        .bus_noe     (bus_noe),
        .bus_nadv    (bus_nadv),
        .bus_addr    (bus_addr),
        .bus_din     (bus_din),
        .rd_word     (rd_word),
        .addr_strobe (addr_strobe),
        .strobe_write(strobe_write),
        .strobe_word (strobe_word),
        .data_fire   (data_fire),
        .wr_data     (wr_data),
        .bus_dout    (bus_dout),
        .bus_doe     (bus_doe)
    );

    psb_fetch_ctrl #(
        .WORD_W(WORD_W),
        .DATA_W(DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_strobe (addr_strobe),
        .strobe_write(strobe_write),
        .strobe_word (strobe_word),
        .data_fire   (data_fire),
        .wr_data     (wr_data),
        .rd_word     (rd_word),
        .bus_nwait   (bus_nwait),
        .usr_valid   (usr_valid),
        .usr_ready   (usr_ready),
        .usr_addr    (usr_addr),
        .usr_write   (usr_write),
        .usr_wdata   (usr_wdata),
        .usr_ack     (usr_ack),
        .usr_rdata   (usr_rdata)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (bus_nwait && !usr_valid && !bus_doe));

endmodule

// File: tb/sim_psram_sync_slave.sv
// Bench for the synchronous PSRAM-style slave bridge: directed corner cases,
// then seeded random traffic, all judged against a bench-side model.
module sim_psram_sync_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ne = 1'b1, bus_nwe = 1'b1, bus_noe = 1'b1, bus_nadv = 1'b1;
    logic [25:0] bus_addr = '0;
    logic [31:0] bus_din = '0;
    logic [31:0] bus_dout;
    logic        bus_doe, bus_nwait;
    logic        usr_valid, usr_write;
    logic        usr_ready = 1'b0, usr_ack = 1'b0;
    logic [23:0] usr_addr;
    logic [31:0] usr_wdata;
    logic [31:0] usr_rdata = '0;

    int errors = 0;
    int checks = 0;

    // Responder bookkeeping and backing store.
    bit          auto_rsp = 1'b1;
    int          req_cnt = 0;
    logic [23:0] last_addr;
    logic        last_wr;
    logic [31:0] last_wd;
    logic [31:0] shadow [16];

    // Bench model of the bridge.
    bit          busy_m = 0, buf_v = 0, pend_w = 0;
    logic [23:0] buf_a = '0, pend_a = '0;
    logic [31:0] buf_d = '0;

    always #5 clk = ~clk;

    psram_sync_slave u0 (
        .clk(clk), .rst_n(rst_n), .bus_ne(bus_ne), .bus_nwe(bus_nwe),
        .bus_noe(bus_noe), .bus_nadv(bus_nadv), .bus_addr(bus_addr),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_nwait(bus_nwait), .usr_valid(usr_valid), .usr_ready(usr_ready),
        .usr_addr(usr_addr), .usr_write(usr_write), .usr_wdata(usr_wdata),
        .usr_ack(usr_ack), .usr_rdata(usr_rdata)
    );

    function automatic logic [31:0] seed_word(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h0101_0101;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Automatic internal responder with short random delays.
    initial begin
        forever begin
            @(negedge clk);
            if (auto_rsp && usr_valid) begin
                repeat ($urandom % 3) @(negedge clk);
                usr_ready = 1'b1;
                @(posedge clk);
                @(negedge clk);
                usr_ready = 1'b0;
                req_cnt++;
                last_addr = usr_addr;
                last_wr   = usr_write;
                last_wd   = usr_wdata;
                if (usr_write) shadow[usr_addr[3:0]] = usr_wdata;
                repeat ($urandom % 3) @(negedge clk);
                usr_rdata = usr_write ? 32'h0 : shadow[last_addr[3:0]];
                usr_ack   = 1'b1;
                @(negedge clk);
                usr_ack   = 1'b0;
            end
        end
    end

    // One bus access plus the model prediction; optional polling of wait.
    task automatic access(input bit wr, input logic [23:0] word, input logic [1:0] boff,
                          input logic [31:0] wdata, input bit coinc, input logic [31:0] cdata,
                          input bit poll, input string tag);
        bit          ignored, exp_req, done;
        logic [31:0] exp_rd;
        int          cnt0;
        exp_rd  = '0;
        exp_req = 0;
        ignored = busy_m;
        if (coinc) begin
            busy_m = 0;
            if (!pend_w) begin buf_v = 1; buf_a = pend_a; buf_d = cdata; end
        end
        if (!ignored) begin
            if (wr) begin
                exp_req = 1; busy_m = 1; buf_v = 0; pend_a = word; pend_w = 1;
            end else if (buf_v && buf_a == word) begin
                exp_rd = buf_d; buf_v = 0;
            end else begin
                exp_req = 1; busy_m = 1; buf_v = 0; pend_a = word; pend_w = 0;
            end
        end
        cnt0 = req_cnt;
        @(negedge clk);
        bus_ne = 0; bus_nadv = 0; bus_nwe = !wr; bus_noe = wr;
        bus_addr = {word, boff}; bus_din = wdata;
        if (coinc) begin usr_ack = 1; usr_rdata = cdata; end
        @(posedge clk);
        @(negedge clk);
        bus_nadv = 1;
        if (coinc) usr_ack = 0;
        chk(bus_nwait == !busy_m, {tag, " wait after address edge"}, 32'(bus_nwait), 32'(!busy_m));
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R3 beat position
        chk(bus_doe == !wr, "R3 doe in beat cycle", 32'(bus_doe), 32'(!wr));
        if (!wr) chk(bus_dout == exp_rd, {tag, " read data"}, bus_dout, exp_rd);
        @(posedge clk);
        @(negedge clk);
        bus_ne = 1; bus_nwe = 1; bus_noe = 1;
        chk(bus_doe == 0, "R3 doe single beat", 32'(bus_doe), 32'h0);
        if (poll) begin
            done = 0;
            for (int i = 0; i < 10; i++) begin
                if (!done) begin
                    if (bus_nwait) done = 1;
                    else @(negedge clk);
                end
            end
            chk(done, {tag, " wait released within poll budget"}, 32'(done), 32'h1);
            if (busy_m) begin
                busy_m = 0;
                if (!pend_w) begin buf_v = 1; buf_a = pend_a; buf_d = shadow[pend_a[3:0]]; end
            end
            chk(req_cnt - cnt0 == int'(exp_req), {tag, " request count"}, 32'(req_cnt - cnt0), 32'(exp_req));
            if (exp_req) begin
                // R2 word address from bits 25:2
                chk(last_addr == word, "R2 request address", 32'(last_addr), 32'(word));
                chk(last_wr == wr, {tag, " request write flag"}, 32'(last_wr), 32'(wr));
                if (wr) chk(last_wd == wdata, "R7 request data", last_wd, wdata);
            end
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [23:0] WA = 24'h000001;
    localparam logic [23:0] WB = 24'hFFFFF2;
    localparam logic [23:0] WC = 24'h5A5A53;
    localparam logic [23:0] WD = 24'h800004;

    initial begin
        logic [23:0] pool [4];
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) shadow[i] = seed_word(i);
        pool[0] = WA; pool[1] = WB; pool[2] = WC; pool[3] = WD;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(bus_nwait == 1, "R1 wait in reset", 32'(bus_nwait), 32'h1);
        chk(usr_valid == 0, "R1 no request in reset", 32'(usr_valid), 32'h0);
        chk(bus_doe == 0, "R1 data bus idle in reset", 32'(bus_doe), 32'h0);
        rst_n = 1;
        @(negedge clk);
        chk(bus_nwait == 1, "R1 wait after reset", 32'(bus_nwait), 32'h1);

        // R4 miss, R2 with nonzero byte offset, R5 hit and consumption
        access(0, WA, 2'b11, '0, 0, '0, 1, "R4");
        access(0, WA, 2'b01, '0, 0, '0, 1, "R5");
        access(0, WA, 2'b00, '0, 0, '0, 1, "R5");
        // R6 other address than the buffered one
        access(0, WB, 2'b00, '0, 0, '0, 1, "R6");
        access(0, WB, 2'b10, '0, 0, '0, 1, "R6");
        // R7 write, then read pair sees new data
        access(1, WA, 2'b00, 32'hA5A5_0F0F, 0, '0, 1, "R7");
        access(0, WA, 2'b00, '0, 0, '0, 1, "R7");
        access(0, WA, 2'b00, '0, 0, '0, 1, "R7");
        // R7 write discards buffered word
        access(0, WB, 2'b00, '0, 0, '0, 1, "R7");
        access(1, WC, 2'b00, 32'h1234_5678, 0, '0, 1, "R7");
        access(0, WB, 2'b00, '0, 0, '0, 1, "R7");

        // R8 request held, busy access ignored; R9 collision
        @(negedge clk);
        while (!bus_nwait) @(negedge clk);
        auto_rsp = 0;
        buf_v = 0;
        access(0, WC, 2'b00, '0, 0, '0, 0, "R4");
        repeat (3) begin
            @(negedge clk);
            chk(usr_valid && usr_addr == WC, "R8 request held", 32'(usr_addr), 32'(WC));
        end
        access(0, WD, 2'b00, '0, 0, '0, 0, "R8");
        chk(usr_addr == WC, "R8 busy access left request alone", 32'(usr_addr), 32'(WC));
        usr_ready = 1;
        @(posedge clk);
        @(negedge clk);
        usr_ready = 0;
        chk(usr_valid == 0, "R8 request handed over", 32'(usr_valid), 32'h0);
        access(0, WD, 2'b00, '0, 1, 32'hC0FF_EE01, 0, "R9");
        @(negedge clk);
        chk(usr_valid == 0, "R9 no request for colliding access", 32'(usr_valid), 32'h0);
        usr_ack = 1; usr_rdata = 32'hDEAD_BEEF;
        @(negedge clk);
        usr_ack = 0;
        auto_rsp = 1;
        // R8 stray acknowledge ignored; R9 acknowledged word kept
        access(0, WC, 2'b00, '0, 0, '0, 1, "R9");

        // Seeded random traffic over a small address pool
        for (int n = 0; n < 150; n++) begin
            bit          wr;
            logic [23:0] w;
            wr = ($urandom % 10) < 3;
            w  = pool[$urandom % 4];
            access(wr, w, 2'($urandom), $urandom, 0, '0, 1, wr ? "R7" : "R4/R5/R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule